// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns one byte at a time into an asynchronous serial frame. A byte is offered on a valid/ready handshake and waits in a one-entry holding stage. On the next oversample tick it moves into the shift sequencer, and at that moment the line settings are captured. The settings are the character length, the stop length, whether a parity bit is sent, how that bit is formed, and a break override. From then on the frame is driven out on `txd`. Each bit lasts `OSR` oversample ticks. The stop time can end on a half-bit boundary.

The block has no baud divider and no queue. The enclosing UART supplies the oversample tick from its rate generator and feeds bytes from its own FIFO. It uses `tx_empty` to see when both the holding stage and the shifter have drained. While the break input is high, the line stays low and no byte is accepted. A frame already in flight keeps its internal timing, but its bits are not visible on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: `wlen_sel` values 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. The data bits go out least significant bit first, and byte bits above the chosen length are never sent.
- R2: Every frame is a start bit at 0, then the data bits, then the optional parity bit, then the stop time at 1. Each start, data and parity bit lasts exactly `OSR` ticks of `os_tick`. Between frames the line rests at 1.
- R3: With `stop_sel`=0 the stop time is `OSR` ticks. With `stop_sel`=1 it is 2·`OSR` ticks, except when `wlen_sel`=0, where it is `OSR`+`OSR`/2 ticks (one and a half bits).
- R4: With `par_en`=0 no parity bit is sent, and the stop time directly follows the last data bit.
- R5: With `par_en`=1 the parity bit is set by `par_mode`, using only the data bits actually sent. Mode 0 makes the count of ones across data and parity odd. Mode 1 makes that count even. Mode 2 always sends 1, and mode 3 always sends 0.
- R6: While `brk` is 1, `txd` is 0 in every cycle, both during a frame and while idle.
- R7: `in_ready` is 1 only when no byte is held, no frame is in progress and `brk` is 0. A byte is taken in a cycle where `in_valid` and `in_ready` are both 1. An `in_valid` held while `brk` is 1 takes nothing.
- R8: `tx_empty` is 1 exactly when the holding stage is empty and no frame is in progress. `busy` is 1 from the tick that starts the frame up to the tick that ends the stop time.
- R9: The line settings are captured on the tick that starts a frame. Changing them during the frame does not alter that frame.
- R10: After reset `txd`=1, `busy`=0, `tx_empty`=1, and `in_ready`=1 if `brk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle oversample strobe, OSR per bit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted |
| in_data | input | 8 | Byte to send |
| wlen_sel | input | 2 | Character length code (0..3 = 5..8 bits) |
| stop_sel | input | 1 | 0: one stop bit; 1: two (1.5 at 5 bits) |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | 0 odd, 1 even, 2 fixed 1, 3 fixed 0 |
| brk | input | 1 | Force line low and refuse bytes |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress in the shifter |
| tx_empty | output | 1 | Holding stage and shifter both empty |

## Verification
The bench builds the block with `OSR`=6 and raises an oversample tick every third clock. Because 6 is not a power of two, a counter that wraps at its natural width would make a bit too long, and the bench would see it. The half-bit stop time becomes 3 ticks, so a stop time of 9 ticks can be told apart from both 6 and 12. The short bit time also allows about fifty complete frames, directed and random, each compared tick by tick against a frame built in the bench.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

   localparam int MIN_BITS = 5;
   localparam int MAX_BITS = 8;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_START  = 3'd1,
      PH_DATA   = 3'd2,
      PH_PARITY = 3'd3,
      PH_STOP   = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ONE  = 2'd2,
      PAR_ZERO = 2'd3
   } par_mode_e;

   typedef struct packed {
      logic [MAX_BITS-1:0] data;
      logic [3:0]          nbits;
      logic                par_on;
      logic                par_val;
   } frame_t;

endpackage

// File: rtl/uart_ftx_frame_calc.sv
module uart_ftx_frame_calc
   import uart_ftx_pkg::*;
#(
   parameter int OSR = 16,
   parameter int TW  = 6
) (
   input  logic [MAX_BITS-1:0] in_data,
   input  logic [1:0]          wlen_sel,
   input  logic                stop_sel,
   input  logic                par_en,
   input  logic [1:0]          par_mode,
   output frame_t              frame,
   output logic [TW-1:0]       stop_ticks
);

   logic [3:0]          nbits;
   logic [MAX_BITS-1:0] data_m;
   logic                ones_odd;

   assign nbits = 4'(MIN_BITS) + {2'b00, wlen_sel};

   for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
      assign data_m[i] = in_data[i] & (4'(i) < nbits);
   end

   assign ones_odd = ^data_m;

   always_comb begin
      frame.data   = data_m;
      frame.nbits  = nbits;
      frame.par_on = par_en;
      unique case (par_mode_e'(par_mode))
         PAR_ODD:  frame.par_val = ~ones_odd;
         PAR_EVEN: frame.par_val = ones_odd;
         PAR_ONE:  frame.par_val = 1'b1;
         default:  frame.par_val = 1'b0;
      endcase
   end

   always_comb begin
      if (!stop_sel)
         stop_ticks = TW'(OSR);
      else if (wlen_sel == 2'd0)
         stop_ticks = TW'(OSR + OSR / 2);
      else
         stop_ticks = TW'(2 * OSR);
   end

endmodule

// File: rtl/uart_ftx_bit_timer.sv
module uart_ftx_bit_timer #(
   parameter int TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          restart,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          phase_done
);

   logic [TW-1:0] cnt;

   assign phase_done = run && tick && (cnt == limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (run && tick)
         cnt <= phase_done ? '0 : cnt + TW'(1);
   end

   // each phase lasts a whole number of ticks: the count never passes its limit
   assert_count_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < limit));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_ftx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic [1:0] wlen_sel,
   input  logic       stop_sel,
   input  logic       par_en,
   input  logic [1:0] par_mode,
   input  logic       brk,
   output logic       txd,
   output logic       busy,
   output logic       tx_empty
);

   localparam int TW = $clog2(2 * OSR + 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("uart_frame_tx: OSR must be even and at least 4");
   end

   phase_e              phase;
   logic                hold_full;
   logic [MAX_BITS-1:0] hold_data;
   logic [MAX_BITS-1:0] shreg;
   logic [2:0]          bit_idx;
   logic                line_q;
   frame_t              fr_q;
   frame_t              fr_calc;
   logic [TW-1:0]       stop_q;
   logic [TW-1:0]       stop_calc;
   logic [TW-1:0]       limit;
   logic                accept;
   logic                load;
   logic                done;
   logic                last_data;

   assign busy     = (phase != PH_IDLE);
   assign in_ready = !hold_full && !busy && !brk;
   assign accept   = in_valid && in_ready;
   assign load     = hold_full && os_tick && !busy;
   assign tx_empty = !hold_full && !busy;
   assign txd      = brk ? 1'b0 : line_q;
   assign limit    = (phase == PH_STOP) ? stop_q : TW'(OSR);
   assign last_data = ({1'b0, bit_idx} == fr_q.nbits - 4'd1);

   uart_ftx_frame_calc #(.OSR(OSR), .TW(TW)) u_calc (
      .in_data    (hold_data),
      .wlen_sel   (wlen_sel),
      .stop_sel   (stop_sel),
      .par_en     (par_en),
      .par_mode   (par_mode),
      .frame      (fr_calc),
      .stop_ticks (stop_calc)
   );

   uart_ftx_bit_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (os_tick),
      .restart    (load),
      .run        (busy),
      .limit      (limit),
      .phase_done (done)
   );

   // holding stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (accept) begin
         hold_full <= 1'b1;
         hold_data <= in_data;
      end else if (load) begin
         hold_full <= 1'b0;
      end
   end

   // frame sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         line_q  <= 1'b1;
         shreg   <= '0;
         bit_idx <= '0;
         fr_q    <= '0;
         stop_q  <= TW'(OSR);
      end else if (load) begin
         phase  <= PH_START;
         line_q <= 1'b0;
         fr_q   <= fr_calc;
         stop_q <= stop_calc;
         shreg  <= fr_calc.data;
      end else if (done) begin
         unique case (phase)
            PH_START: begin
               phase   <= PH_DATA;
               bit_idx <= '0;
               line_q  <= shreg[0];
               shreg   <= shreg >> 1;
            end
            PH_DATA: begin
               if (last_data) begin
                  phase  <= fr_q.par_on ? PH_PARITY : PH_STOP;
                  line_q <= fr_q.par_on ? fr_q.par_val : 1'b1;
               end else begin
                  bit_idx <= bit_idx + 3'd1;
                  line_q  <= shreg[0];
                  shreg   <= shreg >> 1;
               end
            end
            PH_PARITY: begin
               phase  <= PH_STOP;
               line_q <= 1'b1;
            end
            default: begin
               phase  <= PH_IDLE;
               line_q <= 1'b1;
            end
         endcase
      end
   end

   assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> line_q);

   assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line_q);

   assert_data_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> ({1'b0, bit_idx} < fr_q.nbits));

   assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!in_ready && !tx_empty));

   assert_ends_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(line_q));

   assert_load_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hold_full));

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

   localparam int OSR = 6;
   localparam int DIV = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic [1:0] wlen_sel = '0;
   logic       stop_sel = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] par_mode = '0;
   logic       brk = 1'b0;
   logic       txd;
   logic       busy;
   logic       tx_empty;

   int checks = 0;
   int errors = 0;
   int tdiv = 0;
   logic samples [0:255];

   always #10 clk = ~clk;

   uart_frame_tx #(.OSR(OSR)) uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .wlen_sel(wlen_sel), .stop_sel(stop_sel), .par_en(par_en),
      .par_mode(par_mode), .brk(brk), .txd(txd), .busy(busy),
      .tx_empty(tx_empty)
   );

   always @(negedge clk) begin
      if (!rst_n) begin
         tdiv    <= 0;
         os_tick <= 1'b0;
      end else begin
         tdiv    <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
         os_tick <= (tdiv == DIV - 1);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_len(logic [1:0] wl, logic sb, logic pe);
      int st;
      st = !sb ? OSR : (wl == 2'd0 ? OSR + OSR / 2 : 2 * OSR);
      return OSR * (1 + 5 + int'(wl) + int'(pe)) + st;
   endfunction

   function automatic logic exp_at(logic [7:0] d, logic [1:0] wl, logic pe,
                                   logic [1:0] pm, int i);
      int pos;
      int n;
      logic [7:0] m;
      logic p;
      pos = i / OSR;
      n = 5 + int'(wl);
      m = d & ((8'd1 << n) - 8'd1);
      case (pm)
         2'd0: p = ~^m;
         2'd1: p = ^m;
         2'd2: p = 1'b1;
         default: p = 1'b0;
      endcase
      if (pos == 0) return 1'b0;
      if (pos <= n) return d[pos-1];
      if (pe && pos == n + 1) return p;
      return 1'b1;
   endfunction

   // offer one byte, record txd after every tick edge of the frame, compare
   task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic sb,
                       input logic pe, input logic [1:0] pm, input bit scramble,
                       input string req);
      int n;
      int guard;
      int len;
      int bad;
      wlen_sel = wl; stop_sel = sb; par_en = pe; par_mode = pm;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      guard = 0;
      while (!in_ready && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;
      chk(tx_empty == 1'b0, "R8", "tx_empty with byte held", tx_empty, 0);
      n = 0;
      guard = 0;
      while (guard < 4000) begin
         @(negedge clk);
         guard++;
         if (os_tick) begin
            if (busy) begin
               if (n < 256) samples[n] = txd;
               n++;
               if (scramble && n == 2) begin
                  // R9: settings move while the frame runs
                  wlen_sel = $urandom; stop_sel = $urandom;
                  par_en = $urandom; par_mode = $urandom;
               end
            end else if (n > 0) begin
               break;
            end
         end
      end
      len = exp_len(wl, sb, pe);
      chk(n == len, req, "frame length in ticks", n, len);
      bad = -1;
      for (int i = 0; i < len && i < n && i < 256; i++)
         if (bad < 0 && samples[i] !== exp_at(d, wl, pe, pm, i)) bad = i;
      if (bad >= 0)
         chk(1'b0, req, $sformatf("line at tick %0d", bad),
             int'(samples[bad]), int'(exp_at(d, wl, pe, pm, bad)));
      else
         chk(1'b1, req, "line pattern", 0, 0);
      chk(tx_empty && txd && in_ready, "R8", "idle after frame",
          {tx_empty, txd, in_ready}, 3'b111);
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(txd == 1'b1 && busy == 1'b0 && tx_empty == 1'b1 && in_ready == 1'b1,
          "R10", "reset state", {txd, busy, tx_empty, in_ready}, 4'b1011);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: each word length, high bits must not leak out
      send(8'hB5, 2'd0, 1'b0, 1'b0, 2'd0, 0, "R1");
      send(8'hC6, 2'd1, 1'b0, 1'b0, 2'd0, 0, "R1");
      send(8'h2B, 2'd2, 1'b0, 1'b0, 2'd0, 0, "R1");
      send(8'hA7, 2'd3, 1'b0, 1'b0, 2'd0, 0, "R2");
      // R3: stop lengths, incl one and a half at 5 bits
      send(8'h15, 2'd0, 1'b1, 1'b0, 2'd0, 0, "R3");
      send(8'h3C, 2'd1, 1'b1, 1'b0, 2'd0, 0, "R3");
      send(8'hFF, 2'd3, 1'b1, 1'b1, 2'd1, 0, "R3");
      // R5: every parity mode, R4 covered by par_en=0 frames above
      send(8'h01, 2'd3, 1'b0, 1'b1, 2'd0, 0, "R5");
      send(8'h01, 2'd3, 1'b0, 1'b1, 2'd1, 0, "R5");
      send(8'h00, 2'd3, 1'b0, 1'b1, 2'd0, 0, "R5");
      send(8'hE0, 2'd0, 1'b0, 1'b1, 2'd1, 0, "R5");
      send(8'h55, 2'd2, 1'b0, 1'b1, 2'd2, 0, "R5");
      send(8'hAA, 2'd2, 1'b0, 1'b1, 2'd3, 0, "R5");
      send(8'h00, 2'd3, 1'b1, 1'b0, 2'd0, 0, "R4");
      // R9: settings change mid-frame
      send(8'h96, 2'd3, 1'b1, 1'b1, 2'd0, 1, "R9");
      send(8'h4D, 2'd0, 1'b1, 1'b1, 2'd1, 1, "R9");

      // R6 / R7: break while idle refuses the byte and holds line low
      brk = 1'b1;
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'h5A;
      repeat (20) @(negedge clk);
      chk(txd == 1'b0, "R6", "idle line under break", txd, 0);
      chk(in_ready == 1'b0, "R7", "ready under break", in_ready, 0);
      chk(tx_empty == 1'b1 && busy == 1'b0, "R7", "byte refused under break",
          {tx_empty, busy}, 2'b10);
      in_valid = 1'b0;
      brk = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1 && in_ready == 1'b1, "R6", "release of break",
          {txd, in_ready}, 2'b11);

      // R6: break raised in mid-frame
      wlen_sel = 2'd3; stop_sel = 1'b0; par_en = 1'b0;
      in_valid = 1'b1; in_data = 8'hFF;
      @(negedge clk);
      in_valid = 1'b0;
      while (!busy) @(negedge clk);
      repeat (5 * DIV * OSR) @(negedge clk);
      brk = 1'b1;
      begin
         int lows = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
         end
         chk(lows == 20, "R6", "line low in mid-frame break", lows, 20);
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(txd == 1'b0 && in_ready == 1'b0 && tx_empty == 1'b1, "R6",
          "break after frame end", {txd, in_ready, tx_empty}, 3'b001);
      brk = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R2", "line returns high", txd, 1);

      // random frames
      for (int k = 0; k < 36; k++) begin
         d = $urandom;
         send(d, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              1'($urandom), "R2");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule